// File: doc/BRIEF.md
# Log-Depth Priority Selector

This block picks one data word out of N condition/data pairs: the word that travels with the lowest-numbered asserted condition. The result is the same as that of a long if/else-if chain that tests condition 0 first and condition N-1 last. The conditions may overlap, and any number of them may be asserted in the same cycle.

The chain is not built as one serial string of multiplexers. The pairs form a balanced binary tree. Each leaf gates its data word with its own condition. Each internal node merges two neighbouring subtrees with a 2:1 multiplexer. That multiplexer takes the lower-indexed subtree whenever that subtree has a hit, and otherwise takes the upper one. Each node also passes up a hit flag, which is the OR of every condition beneath it. The mux depth is therefore log2(N) rather than N, and the priority order is kept.

The result can be registered once at the output (the default) or left purely combinational. Both the condition count and the word width are parameters. The condition count must be a power of two.

Top module: `prio_tree_sel`

## Requirements
- R1: When one or more conditions are asserted, `word_o` equals the data word whose pair index is the lowest among the asserted conditions. Pair i occupies bits `data_i[i*W +: W]`.
- R2: `found_o` is high exactly when at least one bit of `cond_i` is high.
- R3: When no condition is asserted, `word_o` is all zeros and `found_o` is low.
- R4: When several conditions are asserted together, the data of every asserted pair above the winner has no effect on `word_o`.
- R5: Condition 0 has the highest priority. Whenever `cond_i[0]` is high, `word_o` carries data word 0, whatever the other conditions are.
- R6: Condition N-1 has the lowest priority. It selects data word N-1 only when no other condition is asserted.
- R7: The data words of pairs whose condition is low have no effect on `word_o`.
- R8: With `REG_OUT` = 1, the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, `word_o` is zero and `found_o` is low. With `REG_OUT` = 0, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| cond_i | input | N | Condition vector; bit 0 has the highest priority |
| data_i | input | N*W | Data words; word i is `data_i[i*W +: W]` |
| word_o | output | W | Selected word, or zero when nothing is asserted |
| found_o | output | 1 | High when any condition is asserted |

## Verification
The lower-half-wins rule and the pass-through of the upper half can both be exercised in one cycle. This happens when asserted conditions sit on both sides of one or more split points. The bench provokes this with random overlapping condition vectors. It also drives the all-ones vector. In other cycles it sets only the two boundary indices of a half, and it changes the data of losing pairs while the winner stays asserted. Every cycle is judged against a behavioural model in the bench, which scans the conditions from index 0 upwards, so one pairing error at any tree level shows up as a mismatch in `word_o`.

// File: rtl/prisel_pkg.sv
package prisel_pkg;
    localparam int unsigned DEF_PAIRS = 64;
    localparam int unsigned DEF_WIDTH = 16;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction
endpackage

// File: rtl/prisel_leaf.sv
module prisel_leaf #(
    parameter int unsigned W = 16
) (
    input  logic         cond,
    input  logic [W-1:0] din,
    output logic         hit,
    output logic [W-1:0] dout
);
    always_comb begin
        hit  = cond;
        dout = cond ? din : '0;
    end
endmodule

// File: rtl/prisel_merge.sv
module prisel_merge #(
    parameter int unsigned W = 16
) (
    input  logic         hit_lo,
    input  logic [W-1:0] d_lo,
    input  logic         hit_hi,
    input  logic [W-1:0] d_hi,
    output logic         hit,
    output logic [W-1:0] dout
);
    always_comb begin
        hit  = hit_lo | hit_hi;
        dout = hit_lo ? d_lo : d_hi;
    end
endmodule

// File: rtl/prisel_tree.sv
module prisel_tree #(
    parameter int unsigned N = 64,
    parameter int unsigned W = 16
) (
    input  logic [N-1:0]   cond_i,
    input  logic [N*W-1:0] data_i,
    output logic           hit_o,
    output logic [W-1:0]   word_o
);
    localparam int unsigned NODES = 2 * N - 1;
    localparam int unsigned LEAF0 = N - 1;

    logic [NODES-1:0]        nh;
    logic [NODES-1:0][W-1:0] nd;

    for (genvar i = 0; i < N; i++) begin : g_leaf
        prisel_leaf #(.W(W)) u_leaf (
            .cond (cond_i[i]),
            .din  (data_i[i*W +: W]),
            .hit  (nh[LEAF0 + i]),
            .dout (nd[LEAF0 + i])
        );
    end

    for (genvar k = 0; k < N - 1; k++) begin : g_node
        prisel_merge #(.W(W)) u_merge (
            .hit_lo (nh[2*k + 1]),
            .d_lo   (nd[2*k + 1]),
            .hit_hi (nh[2*k + 2]),
            .d_hi   (nd[2*k + 2]),
            .hit    (nh[k]),
            .dout   (nd[k])
        );
    end

    assign hit_o  = nh[0];
    assign word_o = nd[0];

    // R3: a root without a hit must carry a zero word
    always_comb begin
        if (!$isunknown(cond_i) && !hit_o)
            a_r3_idle_root_zero : assert (word_o == '0);
    end
endmodule

// File: rtl/prio_tree_sel.sv
module prio_tree_sel #(
    parameter int unsigned N       = prisel_pkg::DEF_PAIRS,
    parameter int unsigned W       = prisel_pkg::DEF_WIDTH,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   cond_i,
    input  logic [N*W-1:0] data_i,
    output logic [W-1:0]   word_o,
    output logic           found_o
);
    initial begin
        if (!prisel_pkg::is_pow2(N))
            $error("prio_tree_sel: N must be a power of two");
    end

    logic           root_hit;
    logic [W-1:0]   root_word;

    prisel_tree #(.N(N), .W(W)) u_tree (
        .cond_i (cond_i),
        .data_i (data_i),
        .hit_o  (root_hit),
        .word_o (root_word)
    );

    if (REG_OUT) begin : g_reg
        logic           hit_q;
        logic [W-1:0]   word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hit_q  <= 1'b0;
                word_q <= '0;
            end else begin
                hit_q  <= root_hit;
                word_q <= root_word;
            end
        end

        assign found_o = hit_q;
        assign word_o  = word_q;

        a_r2_found_is_or : assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (found_o == $past(|cond_i)));
        a_r3_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
            (cond_i == '0) |=> (!found_o && word_o == '0));
        a_r5_top_wins : assert property (@(posedge clk) disable iff (!rst_n)
            cond_i[0] |=> (word_o == $past(data_i[W-1:0])));
        a_r6_last_alone : assert property (@(posedge clk) disable iff (!rst_n)
            (cond_i == (N'(1) << (N - 1))) |=> (word_o == $past(data_i[(N-1)*W +: W])));
    end else begin : g_comb
        assign found_o = root_hit;
        assign word_o  = root_word;

        always_comb begin
            if (!$isunknown(cond_i) && cond_i[0])
                a_r5_top_wins_c : assert (word_o == data_i[W-1:0]);
        end
    end
endmodule

// File: tb/prio_tree_sel_test.sv
module prio_tree_sel_test;
    localparam int unsigned N = 64;
    localparam int unsigned W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   cond_i = '0;
    logic [N*W-1:0] data_i = '0;
    logic [W-1:0]   word_o;
    logic           found_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_word = '0;
    logic         exp_found = 1'b0;

    always #10 clk = ~clk;

    prio_tree_sel #(.N(N), .W(W), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .data_i(data_i),
        .word_o(word_o), .found_o(found_o)
    );

    // behavioural reference: scan from index 0 upwards
    task automatic model();
        exp_word  = '0;
        exp_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (cond_i[i] && !exp_found) begin
                exp_found = 1'b1;
                exp_word  = data_i[i*W +: W];
            end
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (word_o !== exp_word || found_o !== exp_found) begin
            errors++;
            $display("FAIL %s: word=%h found=%b expected word=%h found=%b",
                     tag, word_o, found_o, exp_word, exp_found);
        end
    endtask

    task automatic fill_data();
        for (int i = 0; i < N; i++) data_i[i*W +: W] = W'($urandom);
    endtask

    // drive at negedge, register at posedge, judge at next negedge
    task automatic step(input string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        // R8 reset state
        fill_data();
        cond_i = '1;
        @(negedge clk);
        exp_word = '0; exp_found = 1'b0;
        compare("R8 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R3 nothing asserted
        fill_data(); cond_i = '0;
        step("R3 idle");

        // R1 single condition at each index, R5 index 0, R6 index N-1
        for (int i = 0; i < N; i++) begin
            @(negedge clk) ;
            fill_data();
            cond_i = '0; cond_i[i] = 1'b1;
            model();
            @(posedge clk);
            @(negedge clk);
            if (i == 0)          compare("R5 single lowest");
            else if (i == N - 1) compare("R6 single highest");
            else                 compare("R1 single");
        end

        // R5 all asserted
        fill_data(); cond_i = '1;
        step("R5 all asserted");

        // R6 last plus one other: last loses
        fill_data(); cond_i = '0; cond_i[N-1] = 1'b1; cond_i[N/2] = 1'b1;
        step("R6 last loses");

        // R1 boundary of halves
        fill_data(); cond_i = '0; cond_i[N/2-1] = 1'b1; cond_i[N/2] = 1'b1;
        step("R1 half boundary");

        // R4 random overlapping vectors, then change losing data
        for (int t = 0; t < 200; t++) begin
            fill_data();
            cond_i = {$urandom, $urandom};
            if (t % 3 == 0) cond_i = cond_i & {$urandom, $urandom};
            step("R4 overlap");
        end
        for (int t = 0; t < 30; t++) begin
            int lo;
            lo = t % (N - 1);
            cond_i = '0; cond_i[lo] = 1'b1;
            for (int i = lo + 1; i < N; i++) cond_i[i] = $urandom % 2 == 1;
            fill_data();
            step("R4 winner");
            for (int i = lo + 1; i < N; i++) data_i[i*W +: W] = ~data_i[i*W +: W];
            step("R4 losers changed");
        end

        // R7 unasserted data toggled
        for (int t = 0; t < 20; t++) begin
            cond_i = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            for (int i = 0; i < N; i++)
                if (!cond_i[i]) data_i[i*W +: W] = W'($urandom);
            step("R7 unasserted data");
        end

        // R2 found flag around idle/active transitions
        cond_i = '0; step("R2 found low");
        cond_i[N-3] = 1'b1; step("R2 found high");

        // R8 reset mid-run clears the outputs
        cond_i = '1;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        exp_word = '0; exp_found = 1'b0;
        compare("R8 async reset");
        @(negedge clk);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule